// File: doc/BRIEF.md
# Serial Frequency Word Receiver

This block is a write-only serial slave. An external host loads a synthesizer frequency setting through three wires: an active-low chip select, a serial clock and a data line. All three wires are sampled into a faster system clock domain. The block then finds the rising edges of the serial clock and shifts in one data bit at each edge.

Each transfer is 24 bits long and is sent most significant bit first. The two top bits are reserved. The low 22 bits are an unsigned frequency in 1 kHz steps. When chip select returns high after exactly 24 clock rises, the block loads the 22-bit word into its output register and pulses an update strobe for one system cycle. A transfer of any other length is dropped, and the previous setting stays in place.

Top module: `freq_word_rx`

## Requirements
- R1: After reset, `freq_word_o` is zero and `freq_upd_o` is low.
- R2: Bits arrive most significant first, one per serial clock rise while chip select is low. A 24-bit frame loads frame bits 21..0 (the last 22 bits sent) into `freq_word_o`. For example, 2456000 kHz is 0x2579C0.
- R3: Frame bits 23 and 22 (the first two bits sent) have no effect on `freq_word_o`, whatever their value.
- R4: Each accepted frame raises `freq_upd_o` for exactly one system cycle, in the same cycle that the new word appears.
- R5: A frame with fewer than 24 serial clock rises is discarded. There is no strobe, and `freq_word_o` keeps its previous value.
- R6: A frame with more than 24 serial clock rises is discarded. There is no strobe, and `freq_word_o` keeps its previous value.
- R7: Data is taken only at serial clock rises. Changes on the data line while the serial clock is high or low between rises do not alter the received word.
- R8: The bit count and the shift register clear while chip select is high. Serial clock rises seen while chip select is high are ignored, and a discarded partial frame does not affect the next frame.
- R9: The word is committed only when chip select rises. After the 24th clock rise, while chip select is still low, `freq_word_o` and `freq_upd_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_csn_i | input | 1 | Chip select, active low, asynchronous to clk_i |
| spi_sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| spi_sdi_i | input | 1 | Serial data, sampled at serial clock rises |
| freq_word_o | output | 22 | Committed frequency word in kHz |
| freq_upd_o | output | 1 | One-cycle strobe when a new word is committed |

## Verification
Any wrong internal state in this block shows at the ports on the next chip select rise. A bit counter that is off by one turns a valid frame into a discarded one: no strobe appears, and the word stays stale. A bad shift order or a missed edge puts a wrong value on `freq_word_o` three to four system cycles after chip select goes high. A counter that is not cleared between frames makes a valid frame that follows a short frame fail. A counter that wraps makes a long frame be accepted. The directed frames are chosen so that each of these faults changes either the word or the strobe count.

// File: rtl/freq_rx_pkg.sv
package freq_rx_pkg;
  localparam int unsigned FRAME_LEN   = 24;
  localparam int unsigned WORD_LEN    = 22;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/freq_rx_sync.sv
module freq_rx_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/freq_rx_shift.sv
module freq_rx_shift #(
  parameter int unsigned FRAME_LEN = 24,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 shift_en_i,
  input  logic                 bit_i,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic [CNT_W-1:0]     cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] shreg_q;
  logic [CNT_W-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en_i) begin
      shreg_q <= {shreg_q[FRAME_LEN-2:0], bit_i};
      // saturate so an overlong frame can never wrap back to a valid count
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frame_o = shreg_q;
  assign cnt_o   = cnt_q;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R6
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !shift_en_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/freq_rx_commit.sv
module freq_rx_commit #(
  parameter int unsigned FRAME_LEN = 24,
  parameter int unsigned WORD_LEN  = 22,
  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 end_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  output logic [WORD_LEN-1:0]  word_o,
  output logic                 upd_o
);
  logic [WORD_LEN-1:0] word_q;
  logic                upd_q;
  logic                accept;

  assign accept = end_i && (cnt_i == CNT_W'(FRAME_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= accept;
      if (accept) word_q <= frame_i[WORD_LEN-1:0];
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;

  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q); // R4
  AST_WORD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> $stable(word_q)); // R5
endmodule

// File: rtl/freq_word_rx.sv
module freq_word_rx
  import freq_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_LEN,
  parameter int unsigned WORD_BITS  = WORD_LEN,
  parameter int unsigned SYNC_DEPTH = SYNC_STAGES,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 spi_csn_i,
  input  logic                 spi_sclk_i,
  input  logic                 spi_sdi_i,
  output logic [WORD_BITS-1:0] freq_word_o,
  output logic                 freq_upd_o
);
  logic [2:0] pins_s;
  logic       csn_s, sclk_s, sdi_s;
  logic       csn_d, sclk_d;
  logic       sclk_rise, csn_rise;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      cnt;

  freq_rx_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_DEPTH),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_csn_i, spi_sclk_i, spi_sdi_i}),
    .q_o   (pins_s)
  );

  assign {csn_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csn_d  <= csn_s;
      sclk_d <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_d;
  assign csn_rise  = csn_s && !csn_d;

  freq_rx_shift #(.FRAME_LEN(FRAME_BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (csn_s),
    .shift_en_i(sclk_rise && !csn_s),
    .bit_i     (sdi_s),
    .frame_o   (frame),
    .cnt_o     (cnt)
  );

  freq_rx_commit #(.FRAME_LEN(FRAME_BITS), .WORD_LEN(WORD_BITS)) u_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .end_i  (csn_rise),
    .cnt_i  (cnt),
    .frame_i(frame),
    .word_o (freq_word_o),
    .upd_o  (freq_upd_o)
  );

  AST_UPD_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_upd_o |-> ($past(csn_s) && !$past(csn_d))); // R9
  AST_UPD_FULL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_upd_o |-> ($past(cnt) == CNT_W'(FRAME_BITS))); // R2
  AST_UPD_WORD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_upd_o |-> (freq_word_o == $past(frame[WORD_BITS-1:0]))); // R3
endmodule

// File: tb/freq_word_rx_tb_top.sv
module freq_word_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic [21:0] word;
  logic        upd;

  int n_chk = 0;
  int n_err = 0;
  int n_upd = 0;
  int n_wide = 0;
  logic upd_prev = 1'b0;
  logic [21:0] exp_word = '0;

  localparam int HALF = 20;

  always #4 clk = ~clk;

  freq_word_rx dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .spi_csn_i  (csn),
    .spi_sclk_i (sclk),
    .spi_sdi_i  (sdi),
    .freq_word_o(word),
    .freq_upd_o (upd)
  );

  always @(negedge clk) begin
    if (upd) n_upd++;
    if (upd && upd_prev) n_wide++;
    upd_prev = upd;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends nbits bits MSB first; optional garbage on sdi while sclk is high
  task automatic send(input logic [31:0] bits, input int nbits, input bit glitch, input string req);
    int u0, w0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(HALF);
      sclk = 1'b1;
      if (glitch) begin
        wait_clk(6);
        sdi = ~bits[i];
        wait_clk(HALF - 6);
      end else wait_clk(HALF);
      sclk = 1'b0;
      if (glitch) sdi = ~sdi;
    end
    wait_clk(HALF);
    u0 = n_upd;
    w0 = 32'(word);
    // R9: nothing committed while chip select is still low
    chk(32'(word) == 32'(exp_word) && n_upd == u0, "R9", 32'(word), 32'(exp_word));
    csn = 1'b1;
    wait_clk(HALF);
    if (nbits == 24) exp_word = bits[21:0];
    chk(word == exp_word, req, 32'(word), 32'(exp_word));
    chk(n_upd - u0 == (nbits == 24 ? 1 : 0), {req, "/R4 strobe"}, 32'(n_upd - u0), (nbits == 24) ? 1 : 0);
    if (w0 != 32'(exp_word) && nbits != 24) chk(1'b0, req, 32'(w0), 32'(exp_word));
  endtask

  task automatic t_reset;
    wait_clk(1);
    chk(word == 22'd0, "R1 word", 32'(word), 0);
    chk(upd == 1'b0, "R1 upd", 32'(upd), 0);
    rst_n = 1'b1;
    wait_clk(10);
    chk(word == 22'd0 && n_upd == 0, "R1 after release", 32'(word), 0);
  endtask

  task automatic t_basic;
    send(32'h002579C0, 24, 1'b0, "R2 2456000kHz");
    send(32'h00155555, 24, 1'b0, "R2 alternating");
  endtask

  task automatic t_reserved;
    send(32'h00C00001, 24, 1'b0, "R3 reserved 11");
    send(32'h003FFFFF, 24, 1'b0, "R3 reserved 00 all ones");
    send(32'h00800000, 24, 1'b0, "R3 reserved 10 zero word");
  endtask

  task automatic t_short;
    send(32'h0012345, 23, 1'b0, "R5 23 bits");
    send(32'h00000F, 5, 1'b0, "R5 5 bits");
  endtask

  task automatic t_long;
    send(32'h01ABCDEF, 25, 1'b0, "R6 25 bits");
    send(32'h3FFFFFFF, 30, 1'b0, "R6 30 bits");
  endtask

  task automatic t_glitch;
    send(32'h003A5C96, 24, 1'b1, "R7 data moves off edge");
  endtask

  task automatic t_idle_clocks;
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1;
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
    end
    chk(word == exp_word && upd == 1'b0, "R8 clocks with cs high", 32'(word), 32'(exp_word));
    send(32'h000003FF, 10, 1'b0, "R8 partial frame");
    send(32'h00012345, 24, 1'b0, "R8 frame after partial");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_reserved();
    t_short();
    t_long();
    t_glitch();
    t_idle_clocks();
    chk(n_wide == 0, "R4 pulse width", 32'(n_wide), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule